// File: doc/BRIEF.md
# Redirection-Entry Interrupt Dispatcher

This block turns an interrupt event on one input line into interrupt messages for processors. An event carries a line number. The block uses that number to pick a redirection entry from a flat table bus, which storage outside the block keeps up to date. The entry decides what happens next. The event may be dropped. It may raise an error pulse. Or it may produce one or more messages on a valid/ready output stream. Each message carries a target ID, a vector, the delivery mode, the destination mode, a level bit and a trigger bit.

A physical-mode entry produces a single message. A logical-mode entry treats its 8-bit destination as a bitmap and produces one message for each set bit, sent one after another. While messages are still owed, the block refuses new events. It holds every message steady until the receiver accepts it. For the external-interrupt delivery mode, the vector does not come from the entry. It comes from a side input driven by a legacy interrupt controller.

Top module: `irq_redir_dispatch`

## Requirements
- R1: After reset, evtReady is 1 and msgValid, errLine and errMode are all 0.
- R2: An entry has 23 bits, and entry i sits at redirTable[i*23 +: 23]. Within an entry, vector is [7:0], delivery mode is [10:8], destination mode is [11], polarity is [12], trigger is [13], mask is [14] and destination is [22:15]. If an accepted event selects an entry whose mask bit is 1, the event produces no message and no error, even when the entry's delivery mode is a reserved code.
- R3: If an accepted event has a line number of NUM_LINES or more, it produces no message. errLine is then 1 for exactly the one cycle after the accept edge.
- R4: The delivery-mode codes are 0 fixed, 1 lowest priority, 2 system management, 4 non-maskable, 5 init and 7 external. Codes 3 and 6 are reserved. An unmasked entry with a reserved code produces no message. errMode is then 1 for exactly the one cycle after the accept edge.
- R5: An unmasked entry in physical mode (destination mode 0) with a valid code produces exactly one message with msgTarget equal to the destination field. msgValid rises in the cycle after the accept edge.
- R6: An unmasked entry in logical mode (destination mode 1) produces one message for each set bit of the destination. Each message's msgTarget is that bit's index, and the messages go out in ascending index order.
- R7: A logical-mode entry whose destination is zero produces no message and no error.
- R8: If the delivery mode is 7, msgVector is the value of extVector in the cycle the event is accepted. For any other code, msgVector is the entry's vector field.
- R9: Every message copies the entry's delivery mode to msgDelMode, its destination mode to msgDestMode and its trigger bit to msgTrigger. msgLevel equals the entry's polarity bit.
- R10: evtReady is 0 from the accept edge until the last message has been accepted. While msgValid is 1 and msgReady is 0, msgValid and every message field stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | An interrupt event is offered |
| evtReady | output | 1 | The block can accept an event |
| evtLine | input | LINE_W | Input line number of the event |
| redirTable | input | NUM_LINES*23 | Flat redirection table |
| extVector | input | 8 | Vector supplied by the legacy controller |
| msgValid | output | 1 | A message is presented |
| msgReady | input | 1 | The receiver takes the message |
| msgTarget | output | 8 | Target processor ID |
| msgVector | output | 8 | Interrupt vector |
| msgDelMode | output | 3 | Delivery mode |
| msgDestMode | output | 1 | Destination mode |
| msgLevel | output | 1 | Level, taken from the entry's polarity |
| msgTrigger | output | 1 | Trigger mode |
| errLine | output | 1 | One-cycle pulse for an out-of-range line |
| errMode | output | 1 | One-cycle pulse for a reserved delivery mode |

## Verification
A corrupted pending bitmap shows up in the very next message. A target repeats or is skipped, or the order breaks, or the burst ends too early or runs too long. Each of these shows at the port in the first handshake after the fault. A wrong controller state shows up just as fast: evtReady stays asserted while a message is pending, or msgValid appears with no event behind it. If the external vector were sampled at the wrong time, it would show as soon as extVector changes after the accept edge. The stalled handshakes catch any message field that drifts while the output waits.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam int DEST_W = 8;
  localparam int VEC_W  = 8;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWPRI = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSVD3  = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_RSVD6  = 3'd6,
    DM_EXTINT = 3'd7
  } delMode_e;

  // Field order sets the bit layout: vector is the least significant field.
  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              trigger;
    logic              polarity;
    logic              destMode;
    delMode_e          delMode;
    logic [VEC_W-1:0]  vector;
  } redirEntry_t;

  localparam int ENTRY_W = $bits(redirEntry_t);

  typedef struct packed {
    logic load;     // capture the selected entry
    logic advance;  // retire the current message
  } ctrlStrobe_t;

  typedef struct packed {
    logic lineBad;
    logic masked;
    logic reserved;
    logic noTarget;
    logic lastMsg;
  } dpStatus_t;

  function automatic logic isReservedMode(delMode_e m);
    return (m == DM_RSVD3) || (m == DM_RSVD6);
  endfunction

endpackage

// File: rtl/irq_redir_dp.sv
module irq_redir_dp
  import irq_redir_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int LINE_W    = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [LINE_W-1:0]            evtLine,
  input  logic [NUM_LINES*ENTRY_W-1:0] redirTable,
  input  logic [VEC_W-1:0]             extVector,
  input  ctrlStrobe_t                  strobe,
  output dpStatus_t                    status,
  output logic [DEST_W-1:0]            msgTarget,
  output logic [VEC_W-1:0]             msgVector,
  output logic [2:0]                   msgDelMode,
  output logic                         msgDestMode,
  output logic                         msgLevel,
  output logic                         msgTrigger
);

  redirEntry_t entries [NUM_LINES];
  redirEntry_t selEntry;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_unpack
    assign entries[g] = redirTable[g*ENTRY_W +: ENTRY_W];
  end

  logic lineBad;
  assign lineBad = int'(evtLine) >= NUM_LINES;

  always_comb begin
    selEntry = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (int'(evtLine) == i) selEntry = entries[i];
  end

  delMode_e          curMode;
  logic              curDestMode, curLevel, curTrig;
  logic [DEST_W-1:0] curDest, pendMap;
  logic [VEC_W-1:0]  curVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMode     <= DM_FIXED;
      curDestMode <= 1'b0;
      curLevel    <= 1'b0;
      curTrig     <= 1'b0;
      curDest     <= '0;
      curVec      <= '0;
      pendMap     <= '0;
    end else if (strobe.load) begin
      curMode     <= selEntry.delMode;
      curDestMode <= selEntry.destMode;
      curLevel    <= selEntry.polarity;
      curTrig     <= selEntry.trigger;
      curDest     <= selEntry.dest;
      curVec      <= (selEntry.delMode == DM_EXTINT) ? extVector : selEntry.vector;
      pendMap     <= selEntry.dest;
    end else if (strobe.advance) begin
      pendMap     <= pendMap & (pendMap - 1'b1);
    end
  end

  logic [DEST_W-1:0] lowIdx;
  always_comb begin
    lowIdx = '0;
    for (int i = DEST_W-1; i >= 0; i--)
      if (pendMap[i]) lowIdx = DEST_W'(i);
  end

  assign status.lineBad  = lineBad;
  assign status.masked   = selEntry.mask;
  assign status.reserved = isReservedMode(selEntry.delMode);
  assign status.noTarget = selEntry.destMode && (selEntry.dest == '0);
  assign status.lastMsg  = !curDestMode || ((pendMap & (pendMap - 1'b1)) == '0);

  assign msgTarget   = curDestMode ? lowIdx : curDest;
  assign msgVector   = curVec;
  assign msgDelMode  = curMode;
  assign msgDestMode = curDestMode;
  assign msgLevel    = curLevel;
  assign msgTrigger  = curTrig;

endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
  import irq_redir_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evtValid,
  output logic        evtReady,
  output logic        msgValid,
  input  logic        msgReady,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        errLine,
  output logic        errMode
);

  typedef enum logic {ST_IDLE, ST_SEND} state_e;
  state_e state;

  logic accept;
  assign evtReady = (state == ST_IDLE);
  assign msgValid = (state == ST_SEND);
  assign accept   = evtValid && evtReady;

  assign strobe.load    = accept;
  assign strobe.advance = msgValid && msgReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      errLine <= 1'b0;
      errMode <= 1'b0;
    end else begin
      errLine <= 1'b0;
      errMode <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          if (status.lineBad)       errLine <= 1'b1;
          else if (status.masked)   state   <= ST_IDLE;
          else if (status.reserved) errMode <= 1'b1;
          else if (!status.noTarget) state  <= ST_SEND;
        end
        ST_SEND: if (msgReady && status.lastMsg) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/irq_redir_dispatch.sv
module irq_redir_dispatch
  import irq_redir_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int LINE_W    = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         evtValid,
  output logic                         evtReady,
  input  logic [LINE_W-1:0]            evtLine,
  input  logic [NUM_LINES*ENTRY_W-1:0] redirTable,
  input  logic [VEC_W-1:0]             extVector,
  output logic                         msgValid,
  input  logic                         msgReady,
  output logic [DEST_W-1:0]            msgTarget,
  output logic [VEC_W-1:0]             msgVector,
  output logic [2:0]                   msgDelMode,
  output logic                         msgDestMode,
  output logic                         msgLevel,
  output logic                         msgTrigger,
  output logic                         errLine,
  output logic                         errMode
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  irq_redir_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtReady(evtReady),
    .msgValid(msgValid), .msgReady(msgReady), .status(status),
    .strobe(strobe), .errLine(errLine), .errMode(errMode)
  );

  irq_redir_dp #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) dp_i (
    .clk(clk), .rstN(rstN), .evtLine(evtLine), .redirTable(redirTable),
    .extVector(extVector), .strobe(strobe), .status(status),
    .msgTarget(msgTarget), .msgVector(msgVector), .msgDelMode(msgDelMode),
    .msgDestMode(msgDestMode), .msgLevel(msgLevel), .msgTrigger(msgTrigger)
  );

endmodule

// File: rtl/irq_redir_dispatch_chk.sv
module irq_redir_dispatch_chk (
  input logic       clk,
  input logic       rstN,
  input logic       evtReady,
  input logic       msgValid,
  input logic       msgReady,
  input logic [7:0] msgTarget,
  input logic [7:0] msgVector,
  input logic [2:0] msgDelMode,
  input logic       msgDestMode,
  input logic       msgLevel,
  input logic       msgTrigger,
  input logic       errLine,
  input logic       errMode
);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid && $stable(msgTarget) && $stable(msgVector)
      && $stable(msgDelMode) && $stable(msgDestMode) && $stable(msgLevel) && $stable(msgTrigger));

  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> !evtReady);

  // R4
  rsvd_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgDelMode != 3'd3) && (msgDelMode != 3'd6));

  // R6
  ascending_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgDestMode && $past(msgValid && msgReady && msgDestMode)
      |-> msgTarget > $past(msgTarget));

  // R3
  err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errLine, errMode}));

  // R4
  err_nomsg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errLine || errMode) |-> !msgValid && evtReady);

endmodule

bind irq_redir_dispatch irq_redir_dispatch_chk chk_i (.*);

// File: tb/irq_redir_dispatch_tb.sv
`timescale 1ns/1ps
module irq_redir_dispatch_tb_top;

  localparam int NUM_LINES = 24;
  localparam int LINE_W    = 5;
  localparam int EW        = 23;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtValid = 1'b0;
  logic [LINE_W-1:0] evtLine = '0;
  logic [NUM_LINES*EW-1:0] tbl = '0;
  logic [7:0] extVector = '0;
  logic msgReady = 1'b0;
  logic evtReady, msgValid, msgDestMode, msgLevel, msgTrigger, errLine, errMode;
  logic [7:0] msgTarget, msgVector;
  logic [2:0] msgDelMode;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  irq_redir_dispatch #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) dut_i (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtReady(evtReady),
    .evtLine(evtLine), .redirTable(tbl), .extVector(extVector),
    .msgValid(msgValid), .msgReady(msgReady), .msgTarget(msgTarget),
    .msgVector(msgVector), .msgDelMode(msgDelMode), .msgDestMode(msgDestMode),
    .msgLevel(msgLevel), .msgTrigger(msgTrigger), .errLine(errLine), .errMode(errMode)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int nthBit(input logic [7:0] m, input int n);
    int seen = 0;
    for (int i = 0; i < 8; i++)
      if (m[i]) begin
        if (seen == n) return i;
        seen++;
      end
    return -1;
  endfunction

  typedef struct packed {
    logic [7:0] line;
    logic [7:0] vec;
    logic [2:0] mode;
    logic       dm;
    logic       pol;
    logic       trg;
    logic       mask;
    logic [7:0] dest;
    logic [7:0] ext;
    logic [3:0] cnt;
    logic       errL;
    logic       errM;
  } tv_t;

  localparam int NV = 13;
  localparam tv_t VECS [NV] = '{
    '{8'd3,  8'h41, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h05, 8'h00, 4'd1, 1'b0, 1'b0}, // R5 physical
    '{8'd7,  8'h22, 3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA5, 8'h00, 4'd4, 1'b0, 1'b0}, // R6 fan-out
    '{8'd0,  8'h30, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01, 8'h00, 4'd0, 1'b0, 1'b0}, // R2 masked
    '{8'd23, 8'h10, 3'd7, 1'b0, 1'b1, 1'b1, 1'b0, 8'h0F, 8'h99, 4'd1, 1'b0, 1'b0}, // R8 external
    '{8'd5,  8'h11, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 8'h00, 4'd0, 1'b0, 1'b1}, // R4 code 3
    '{8'd6,  8'h12, 3'd6, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 4'd0, 1'b0, 1'b1}, // R4 code 6
    '{8'd2,  8'h13, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 4'd0, 1'b0, 1'b0}, // R7 empty map
    '{8'd24, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'd0, 1'b1, 1'b0}, // R3 edge
    '{8'd31, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'd0, 1'b1, 1'b0}, // R3 max
    '{8'd9,  8'h44, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 8'h81, 8'h5A, 4'd2, 1'b0, 1'b0}, // R8 logical
    '{8'd10, 8'h55, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h00, 4'd8, 1'b0, 1'b0}, // R6 all bits
    '{8'd11, 8'h66, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h04, 8'h00, 4'd0, 1'b0, 1'b0}, // R2 mask wins
    '{8'd1,  8'h77, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h00, 4'd1, 1'b0, 1'b0}  // R9 fields
  };

  task automatic runEvent(input tv_t v);
    int got = 0;
    logic [7:0] expVec;
    logic [7:0] tgt, vecS;
    logic [2:0] modeS;
    logic dmS, lvS, trS;
    if (v.line < NUM_LINES)
      tbl[int'(v.line)*EW +: EW] = {v.dest, v.mask, v.trg, v.pol, v.dm, v.mode, v.vec};
    expVec = (v.mode == 3'd7) ? v.ext : v.vec;
    evtLine   = v.line[LINE_W-1:0];
    extVector = v.ext;
    evtValid  = 1'b1;
    chk(evtReady == 1'b1, "R10", "ready before event", int'(evtReady), 1);
    @(negedge clk);
    evtValid  = 1'b0;
    extVector = ~v.ext;                 // R8: later changes must not matter
    chk(errLine == v.errL, "R3", "errLine pulse", int'(errLine), int'(v.errL));
    chk(errMode == v.errM, "R4", "errMode pulse", int'(errMode), int'(v.errM));
    while (msgValid && got < 12) begin
      int expT = v.dm ? nthBit(v.dest, got) : int'(v.dest);
      chk(int'(msgTarget) == expT, v.dm ? "R6" : "R5", "target", int'(msgTarget), expT);
      chk(msgVector == expVec, "R8", "vector", int'(msgVector), int'(expVec));
      chk(msgDelMode == v.mode && msgDestMode == v.dm && msgLevel == v.pol
          && msgTrigger == v.trg, "R9", "fields",
          int'({msgDelMode, msgDestMode, msgLevel, msgTrigger}),
          int'({v.mode, v.dm, v.pol, v.trg}));
      chk(evtReady == 1'b0, "R10", "ready while busy", int'(evtReady), 0);
      tgt = msgTarget; vecS = msgVector; modeS = msgDelMode;
      dmS = msgDestMode; lvS = msgLevel; trS = msgTrigger;
      @(negedge clk);
      chk(msgValid && msgTarget == tgt && msgVector == vecS && msgDelMode == modeS
          && msgDestMode == dmS && msgLevel == lvS && msgTrigger == trS,
          "R10", "stable under stall", int'(msgTarget), int'(tgt));
      msgReady = 1'b1;
      @(negedge clk);
      msgReady = 1'b0;
      got++;
    end
    chk(got == int'(v.cnt), "R6", "message count", got, int'(v.cnt));
    chk(evtReady == 1'b1, "R10", "ready after burst", int'(evtReady), 1);
    @(negedge clk);
    chk(!errLine && !errMode && !msgValid, "R3", "pulse single cycle",
        int'({errLine, errMode, msgValid}), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(evtReady == 1'b1, "R1", "evtReady", int'(evtReady), 1);
    chk(msgValid == 1'b0, "R1", "msgValid", int'(msgValid), 0);
    chk(!errLine && !errMode, "R1", "errors", int'({errLine, errMode}), 0);

    // every slot starts masked
    for (int i = 0; i < NUM_LINES; i++) tbl[i*EW + 14] = 1'b1;

    for (int k = 0; k < NV; k++) runEvent(VECS[k]);

    // R6 directed: a single high bit in logical mode, then a reused line
    runEvent('{8'd4, 8'hE1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h80, 8'h00, 4'd1, 1'b0, 1'b0});
    // R5 directed: back-to-back events on the same line with a new entry
    runEvent('{8'd4, 8'hE2, 3'd5, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 4'd1, 1'b0, 1'b0});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule